// File: doc/BRIEF.md
# Left-justified audio serial port master

This block is the controller end of a serial audio link to a stereo codec. One free-running counter on the master clock, which runs at 256 times the sample rate, produces the bit clock and the word-select clock. The bit clock is the master clock divided by four, giving 64 bit periods per frame. Word-select is low for the 32 bit periods of the left half and high for the 32 bit periods of the right half. A frame starts at the falling edge of word-select.

Playback samples are 20 bits wide. They are sent left-justified and MSB first. The MSB occupies the first bit period after a word-select transition, and the 12 bit periods that remain in each half carry zeros. Serial data changes on the rising bit-clock edge, and capture data is sampled on the falling edge.

On the parallel side, playback and capture are separate. Each has a valid/ready pair that moves one stereo pair per frame, with one-cycle flags for a missing playback pair and for a capture pair that was overwritten.

Top module: `lj_audio_master`

## Requirements
- R1: `bclk_o` has a period of four master clocks, with two clocks high followed by two clocks low.
- R2: `ws_o` holds each level for exactly 128 master clocks and changes only in the cycle in which `bclk_o` rises. The left half is sent while `ws_o` is 0 and the right half while it is 1.
- R3: While `rst_ni` is low, the outputs are `ws_o`=1, `bclk_o`=0, `sdo_o`=0, `pb_ready_o`=0, `cap_valid_o`=0, `underrun_o`=0 and `overrun_o`=0. The first falling edge of `ws_o` comes at the first master-clock edge after reset is released.
- R4: In each half, `sdo_o` carries bit 19 of that channel's sample during the first bit period, and the lower bits follow in descending order over the next 19 bit periods.
- R5: `sdo_o` is 0 during bit periods 21 to 32 of every half.
- R6: `pb_ready_o` is high for exactly one master clock per frame, the clock just before `ws_o` falls. A pair is taken when `pb_valid_i` is high in that clock.
- R7: If `pb_valid_i` is low when `pb_ready_o` is high, both halves of the next frame send all zeros, and `underrun_o` is high for one clock, the first clock of that frame.
- R8: `sdi_i` is sampled at each falling edge of `bclk_o` during bit periods 1 to 20 of each half. The first bit sampled becomes bit 19 of the captured channel word.
- R9: `sdi_i` has no effect on the captured words during bit periods 21 to 32.
- R10: The pair captured in a frame appears on `cap_left_o`/`cap_right_o` with `cap_valid_o`=1 in the clock in which `ws_o` falls to start the next frame. It is then held stable until `cap_ready_i` is high. No pair is published before the first full frame after reset.
- R11: If `cap_valid_o` is still high and `cap_ready_i` is low when a new pair is published, the new pair replaces the old one and `overrun_o` is high for one clock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Master clock, 256 times the sample rate |
| rst_ni | input | 1 | Asynchronous reset, active low |
| bclk_o | output | 1 | Bit clock to the codec |
| ws_o | output | 1 | Word select: 0 for the left half, 1 for the right half |
| sdo_o | output | 1 | Serial playback data |
| sdi_i | input | 1 | Serial capture data |
| pb_valid_i | input | 1 | Playback pair valid |
| pb_ready_o | output | 1 | Playback pair taken this clock |
| pb_left_i | input | 20 | Playback left sample |
| pb_right_i | input | 20 | Playback right sample |
| underrun_o | output | 1 | One-clock pulse: frame sent without a pair |
| cap_valid_o | output | 1 | Captured pair valid |
| cap_ready_i | input | 1 | Captured pair accepted |
| cap_left_o | output | 20 | Captured left sample |
| cap_right_o | output | 20 | Captured right sample |
| overrun_o | output | 1 | One-clock pulse: unaccepted pair overwritten |

## Verification
The hardest situation to reach is an overrun whose replacement data must still be correct. It needs a pair published, left unaccepted for a whole frame, and a second pair then published over it, all while serial capture keeps running. The stimulus drives several directed frames with `cap_ready_i` held low back to back, and the random frames drop ready often. The bench predicts the pending state of the capture side from frame to frame. It drives random bits into the unused tail of each half, so that any leak of those bits into the captured words is visible.

// File: rtl/lj_pkg.sv
package lj_pkg;
  localparam int SAMPLE_W  = 20;  // bits per channel sample
  localparam int DIV_LOG2  = 2;   // master clocks per bit clock = 2**DIV_LOG2
  localparam int SLOT_LOG2 = 5;   // bit clocks per half frame = 2**SLOT_LOG2
endpackage

// File: rtl/lj_clkgen.sv
module lj_clkgen #(
  parameter int DIV_LOG2  = lj_pkg::DIV_LOG2,
  parameter int SLOT_LOG2 = lj_pkg::SLOT_LOG2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  output logic                 bclk_o,
  output logic                 ws_o,
  output logic                 frame_last_o,
  output logic                 tx_step_o,
  output logic                 rx_step_o,
  output logic [SLOT_LOG2-1:0] cur_bit_o,
  output logic                 cur_half_o,
  output logic [SLOT_LOG2-1:0] nxt_bit_o,
  output logic                 nxt_half_o
);
  localparam int CNT_W   = DIV_LOG2 + SLOT_LOG2 + 1;
  localparam int FALL_PH = (1 << DIV_LOG2) / 2 - 1;

  logic [CNT_W-1:0] cnt_q, cnt_nxt;

  assign cnt_nxt = cnt_q + CNT_W'(1);

  // reset to all ones: ws high, next edge opens a left half
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) cnt_q <= '1;
    else         cnt_q <= cnt_nxt;
  end

  assign bclk_o       = ~cnt_q[DIV_LOG2-1];
  assign ws_o         = cnt_q[CNT_W-1];
  assign frame_last_o = rst_ni & (&cnt_q);
  assign tx_step_o    = &cnt_q[DIV_LOG2-1:0];
  assign rx_step_o    = cnt_q[DIV_LOG2-1:0] == DIV_LOG2'(FALL_PH);
  assign cur_bit_o    = cnt_q[DIV_LOG2 +: SLOT_LOG2];
  assign cur_half_o   = cnt_q[CNT_W-1];
  assign nxt_bit_o    = cnt_nxt[DIV_LOG2 +: SLOT_LOG2];
  assign nxt_half_o   = cnt_nxt[CNT_W-1];

  p_bclk_high_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(bclk_o) |=> bclk_o);
  p_bclk_low_r1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $fell(bclk_o) |=> !bclk_o);
  p_ws_on_rise_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ws_o != $past(ws_o)) |-> $rose(bclk_o));
  p_frame_start_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    frame_last_o |=> (!ws_o && cur_bit_o == '0));
endmodule

// File: rtl/lj_tx.sv
module lj_tx #(
  parameter int SAMPLE_W  = lj_pkg::SAMPLE_W,
  parameter int SLOT_LOG2 = lj_pkg::SLOT_LOG2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_last_i,
  input  logic                 tx_step_i,
  input  logic [SLOT_LOG2-1:0] cur_bit_i,
  input  logic [SLOT_LOG2-1:0] nxt_bit_i,
  input  logic                 nxt_half_i,
  input  logic                 pb_valid_i,
  input  logic [SAMPLE_W-1:0]  pb_left_i,
  input  logic [SAMPLE_W-1:0]  pb_right_i,
  output logic                 pb_ready_o,
  output logic                 underrun_o,
  output logic                 sdo_o
);
  localparam logic [SLOT_LOG2-1:0] DATA_SLOTS = SLOT_LOG2'(SAMPLE_W);

  logic [SAMPLE_W-1:0] right_q, sh_q, load_word;
  logic                sdo_q, und_q;

  assign pb_ready_o = frame_last_i;

  // left word only starts at the frame_last edge, so it comes straight from the port
  assign load_word = nxt_half_i ? right_q : (pb_valid_i ? pb_left_i : '0);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      right_q <= '0;
      sh_q    <= '0;
      sdo_q   <= 1'b0;
      und_q   <= 1'b0;
    end else begin
      und_q <= frame_last_i & ~pb_valid_i;
      if (frame_last_i) right_q <= pb_valid_i ? pb_right_i : '0;
      if (tx_step_i) begin
        if (nxt_bit_i == '0) begin
          sdo_q <= load_word[SAMPLE_W-1];
          sh_q  <= {load_word[SAMPLE_W-2:0], 1'b0};
        end else if (nxt_bit_i < DATA_SLOTS) begin
          sdo_q <= sh_q[SAMPLE_W-1];
          sh_q  <= {sh_q[SAMPLE_W-2:0], 1'b0};
        end else begin
          sdo_q <= 1'b0;
        end
      end
    end
  end

  assign sdo_o      = sdo_q;
  assign underrun_o = und_q;

  p_sdo_tail_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cur_bit_i >= DATA_SLOTS) |-> !sdo_o);
  p_underrun_silent_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |-> !sdo_o);
  p_underrun_pulse_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    underrun_o |=> !underrun_o);
  p_ready_single_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pb_ready_o |=> !pb_ready_o);
endmodule

// File: rtl/lj_rx.sv
module lj_rx #(
  parameter int SAMPLE_W  = lj_pkg::SAMPLE_W,
  parameter int SLOT_LOG2 = lj_pkg::SLOT_LOG2
) (
  input  logic                 clk_i,
  input  logic                 rst_ni,
  input  logic                 frame_last_i,
  input  logic                 rx_step_i,
  input  logic [SLOT_LOG2-1:0] cur_bit_i,
  input  logic                 cur_half_i,
  input  logic                 sdi_i,
  input  logic                 cap_ready_i,
  output logic                 cap_valid_o,
  output logic [SAMPLE_W-1:0]  cap_left_o,
  output logic [SAMPLE_W-1:0]  cap_right_o,
  output logic                 overrun_o
);
  localparam logic [SLOT_LOG2-1:0] DATA_SLOTS = SLOT_LOG2'(SAMPLE_W);

  logic [SAMPLE_W-1:0] rx_l_q, rx_r_q, cap_l_q, cap_r_q;
  logic                run_q, valid_q, ovr_q, publish, take_bit;

  assign publish  = frame_last_i & run_q;
  assign take_bit = rx_step_i & (cur_bit_i < DATA_SLOTS);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      run_q   <= 1'b0;
      rx_l_q  <= '0;
      rx_r_q  <= '0;
      cap_l_q <= '0;
      cap_r_q <= '0;
      valid_q <= 1'b0;
      ovr_q   <= 1'b0;
    end else begin
      if (frame_last_i) run_q <= 1'b1;
      if (take_bit) begin
        if (cur_half_i) rx_r_q <= {rx_r_q[SAMPLE_W-2:0], sdi_i};
        else            rx_l_q <= {rx_l_q[SAMPLE_W-2:0], sdi_i};
      end
      ovr_q <= publish & valid_q & ~cap_ready_i;
      if (publish) begin
        valid_q <= 1'b1;
        cap_l_q <= rx_l_q;
        cap_r_q <= rx_r_q;
      end else if (cap_ready_i) begin
        valid_q <= 1'b0;
      end
    end
  end

  assign cap_valid_o = valid_q;
  assign cap_left_o  = cap_l_q;
  assign cap_right_o = cap_r_q;
  assign overrun_o   = ovr_q;

  p_overrun_valid_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |-> cap_valid_o);
  p_overrun_pulse_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    overrun_o |=> !overrun_o);
  p_hold_pair_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cap_valid_o && !cap_ready_i && !frame_last_i) |=>
      (cap_valid_o && $stable(cap_left_o) && $stable(cap_right_o)));
endmodule

// File: rtl/lj_audio_master.sv
module lj_audio_master #(
  parameter int SAMPLE_W  = lj_pkg::SAMPLE_W,
  parameter int DIV_LOG2  = lj_pkg::DIV_LOG2,
  parameter int SLOT_LOG2 = lj_pkg::SLOT_LOG2
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  output logic                bclk_o,
  output logic                ws_o,
  output logic                sdo_o,
  input  logic                sdi_i,
  input  logic                pb_valid_i,
  output logic                pb_ready_o,
  input  logic [SAMPLE_W-1:0] pb_left_i,
  input  logic [SAMPLE_W-1:0] pb_right_i,
  output logic                underrun_o,
  output logic                cap_valid_o,
  input  logic                cap_ready_i,
  output logic [SAMPLE_W-1:0] cap_left_o,
  output logic [SAMPLE_W-1:0] cap_right_o,
  output logic                overrun_o
);
  logic                 frame_last, tx_step, rx_step, cur_half, nxt_half;
  logic [SLOT_LOG2-1:0] cur_bit, nxt_bit;

  lj_clkgen #(.DIV_LOG2(DIV_LOG2), .SLOT_LOG2(SLOT_LOG2)) u_clkgen (
    .clk_i, .rst_ni, .bclk_o, .ws_o,
    .frame_last_o(frame_last), .tx_step_o(tx_step), .rx_step_o(rx_step),
    .cur_bit_o(cur_bit), .cur_half_o(cur_half),
    .nxt_bit_o(nxt_bit), .nxt_half_o(nxt_half)
  );

  lj_tx #(.SAMPLE_W(SAMPLE_W), .SLOT_LOG2(SLOT_LOG2)) u_tx (
    .clk_i, .rst_ni, .frame_last_i(frame_last), .tx_step_i(tx_step),
    .cur_bit_i(cur_bit), .nxt_bit_i(nxt_bit), .nxt_half_i(nxt_half),
    .pb_valid_i, .pb_left_i, .pb_right_i, .pb_ready_o, .underrun_o, .sdo_o
  );

  lj_rx #(.SAMPLE_W(SAMPLE_W), .SLOT_LOG2(SLOT_LOG2)) u_rx (
    .clk_i, .rst_ni, .frame_last_i(frame_last), .rx_step_i(rx_step),
    .cur_bit_i(cur_bit), .cur_half_i(cur_half), .sdi_i, .cap_ready_i,
    .cap_valid_o, .cap_left_o, .cap_right_o, .overrun_o
  );

  p_reset_idle_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(rst_ni) |-> (!cap_valid_o && !sdo_o));
endmodule

// File: tb/lj_audio_master_test.sv
module lj_audio_master_test;
  localparam int CLK_P = 10;
  localparam int W     = 20;

  logic         clk = 1'b0, rst_n = 1'b0;
  logic         bclk_o, ws_o, sdo_o, pb_ready_o, underrun_o, cap_valid_o, overrun_o;
  logic         sdi_i = 1'b0, pb_valid_i = 1'b0, cap_ready_i = 1'b0;
  logic [W-1:0] pb_left_i = '0, pb_right_i = '0, cap_left_o, cap_right_o;

  int  checks = 0, fails = 0, und_cnt = 0, ovr_cnt = 0;
  bit  done = 0, has_prev = 0, pending = 0;
  logic [W-1:0] prev_l, prev_r;
  time t_rel, t_ws;

  always #(CLK_P/2) clk = ~clk;

  lj_audio_master uut (
    .clk_i(clk), .rst_ni(rst_n), .bclk_o, .ws_o, .sdo_o, .sdi_i,
    .pb_valid_i, .pb_ready_o, .pb_left_i, .pb_right_i, .underrun_o,
    .cap_valid_o, .cap_ready_i, .cap_left_o, .cap_right_o, .overrun_o
  );

  task automatic check(input bit ok, input string req, input string what,
                       input longint unsigned act, input longint unsigned exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // pulse counters
  always @(negedge clk) begin
    if (rst_n && underrun_o) und_cnt++;
    if (rst_n && overrun_o)  ovr_cnt++;
  end

  // clock shape monitor: R1, R2, R6
  bit mon_on = 0, first_ws = 1, first_b = 1;
  logic p_ws, p_bclk, p_rdy;
  int ws_run, b_run;
  always @(negedge clk) begin
    if (!rst_n || done) begin
      mon_on = 0;
    end else if (!mon_on) begin
      mon_on = 1; first_ws = 1; first_b = 1;
      p_ws = ws_o; p_bclk = bclk_o; p_rdy = pb_ready_o; ws_run = 1; b_run = 1;
    end else begin
      if (ws_o != p_ws) begin
        check(bclk_o && !p_bclk, "R2", "ws change without bclk rise", bclk_o, 1);
        if (!first_ws) check(ws_run == 128, "R2", "ws level length", ws_run, 128);
        if (!ws_o) check(p_rdy, "R6", "pb_ready before ws fall", p_rdy, 1);
        first_ws = 0; ws_run = 1;
      end else ws_run++;
      if (bclk_o != p_bclk) begin
        if (!first_b) check(b_run == 2, "R1", "bclk level length", b_run, 2);
        first_b = 0; b_run = 1;
      end else b_run++;
      if (pb_ready_o) check(!p_rdy, "R6", "pb_ready longer than one clock", 2, 1);
      p_ws = ws_o; p_bclk = bclk_o; p_rdy = pb_ready_o;
    end
  end

  // codec side of one frame plus parallel-side setup
  task automatic run_frame(input logic [W-1:0] cl, cr, input bit v,
                           input logic [W-1:0] pl, pr, input bit rdy);
    logic [W-1:0] gw [2];
    logic [W-1:0] word;
    bit tail, ws_bad, exp_ovr;
    int u0, o0;
    pb_valid_i = v; pb_left_i = pl; pb_right_i = pr; cap_ready_i = rdy;
    @(negedge ws_o);
    t_ws = $time;
    #1;
    u0 = und_cnt; o0 = ovr_cnt;
    if (has_prev) begin
      check(cap_valid_o, "R10", "cap_valid at publish", cap_valid_o, 1);
      check(cap_left_o == prev_l, "R8 R9", "captured left", cap_left_o, prev_l);
      check(cap_right_o == prev_r, "R8 R9", "captured right", cap_right_o, prev_r);
    end else begin
      check(!cap_valid_o, "R10", "no publish before first frame", cap_valid_o, 0);
    end
    exp_ovr = has_prev && pending && !rdy;
    if (has_prev) pending = !rdy;
    pb_valid_i = 1'b0;
    tail = 0; ws_bad = 0; gw[0] = '0; gw[1] = '0;
    for (int h = 0; h < 2; h++) begin
      word = h ? cr : cl;
      for (int b = 0; b < 32; b++) begin
        sdi_i = (b < W) ? word[W-1-b] : 1'($urandom % 2);
        @(negedge bclk_o); #1;
        if (b < W) gw[h][W-1-b] = sdo_o;
        else tail |= sdo_o;
        if (ws_o != 1'(h)) ws_bad = 1;
        if (!(h == 1 && b == 31)) begin
          @(posedge bclk_o); #1;
        end
      end
    end
    check(!ws_bad, "R2", "ws level per half", ws_bad, 0);
    check(gw[0] == (v ? pl : '0), "R4 R7", "sent left", gw[0], v ? pl : 0);
    check(gw[1] == (v ? pr : '0), "R4 R7", "sent right", gw[1], v ? pr : 0);
    check(!tail, "R5", "tail bits zero", tail, 0);
    check((und_cnt - u0) == (v ? 0 : 1), "R7", "underrun pulses", und_cnt - u0, v ? 0 : 1);
    check((ovr_cnt - o0) == int'(exp_ovr), "R11", "overrun pulses", ovr_cnt - o0, exp_ovr);
    check(cap_valid_o == pending, "R10", "cap_valid held", cap_valid_o, pending);
    prev_l = cl; prev_r = cr; has_prev = 1;
  endtask

  initial begin
    #(CLK_P * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=timeout expected=finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    int seed;
    seed = $urandom(32'd1234);
    repeat (3) @(negedge clk);
    check(ws_o == 1, "R3", "reset ws", ws_o, 1);
    check(bclk_o == 0, "R3", "reset bclk", bclk_o, 0);
    check(sdo_o == 0, "R3", "reset sdo", sdo_o, 0);
    check(pb_ready_o == 0, "R3", "reset pb_ready", pb_ready_o, 0);
    check(cap_valid_o == 0, "R3", "reset cap_valid", cap_valid_o, 0);
    check(!underrun_o && !overrun_o, "R3", "reset flags", {underrun_o, overrun_o}, 0);
    rst_n = 1'b1;
    t_rel = $time;
    run_frame(20'h12345, 20'hABCDE, 1, 20'h80001, 20'h7FFFE, 1);
    check(t_ws - t_rel == CLK_P/2, "R3", "first ws fall delay", t_ws - t_rel, CLK_P/2);
    run_frame(20'hFFFFF, 20'h00001, 1, 20'hFFFFF, 20'h00000, 1);
    run_frame(20'h80000, 20'h55555, 0, 20'h13579, 20'h2468A, 0);  // underrun
    run_frame(20'hAAAAA, 20'h0F0F0, 1, 20'h00001, 20'h80000, 0);  // overrun
    run_frame(20'h00000, 20'hFFFFF, 1, 20'hC3C3C, 20'h3C3C3, 0);  // overrun again
    run_frame(20'h11111, 20'h22222, 1, 20'h33333, 20'h44444, 1);
    for (int i = 0; i < 20; i++) begin
      run_frame(W'($urandom), W'($urandom), ($urandom % 4) != 0,
                W'($urandom), W'($urandom), ($urandom % 3) != 0);
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule